// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Tracker

This block sits beside the command bus of an SDRAM controller. It watches every registered command to a four-bank device and keeps a cycle-exact picture of that device. The picture covers which bank drives or takes the data bus and in which direction, when an interrupted burst stops, when each bank's internal precharge begins, and when the controller had to mask the bus with DQM to avoid a turnaround clash. A controller, a bus monitor or a protocol scoreboard can use these outputs to check its own scheduling.

The central case is a burst on one bank cut short by a READ or WRITE to another bank. The point at which the cut-off burst stops depends on whether it is a read or a write and on what interrupts it. So does the cycle in which that bank's auto precharge starts. CAS latency (2 or 3) and burst length (1, 2, 4 or 8) are run-time inputs that stay fixed while traffic flows. Write recovery and precharge duration are parameters. A READ or WRITE to a bank that cannot take it raises an error pulse, and the tracker ignores that command.

Top module: `sdram_cap_tracker`

## Requirements
- R1: In reset and until the first command, bus_dir_o is 0 (idle), bus_bank_o, pre_start_o and dqm_lead_o are 0, and dqm_req_o and err_o are low.
- R2: An accepted WRITE (cmd_i=3) owns the bus in write direction (bus_dir_o=2, bus_bank_o=its bank) for BL cycles, starting in the cycle it is registered. BL = 1 << burst_len_i.
- R3: An accepted READ (cmd_i=2) owns the bus in read direction (bus_dir_o=1) for BL cycles, starting CL cycles after it is registered. CL is 3 when cas3_i=1 and 2 otherwise.
- R4: If a READ to bank m is registered while bank n's read is running, bank n keeps the bus until bank m's data starts CL cycles later. Bank n loses the bus in that cycle.
- R5: If a WRITE to bank m is registered while read data is due or flowing, the read stops in that same cycle and bank m's write owns the bus. Read data not yet started is dropped.
- R6: If a READ or WRITE to bank m is registered during bank n's write burst, bank n's last write cycle is the cycle before. After a READ, the bus stays idle until bank m's data starts CL cycles later.
- R7: A WRITE that cuts off read traffic (R5) pulses dqm_req_o in the cycle it is registered. dqm_lead_o then gives the required DQM lead: 2 clocks if the last accepted read carried auto precharge, otherwise 1.
- R8: A read with auto precharge pulses pre_start_o[bank] in the cycle another bank's READ or WRITE interrupts it. If nothing interrupts it, the pulse comes BL cycles after the read is registered.
- R9: A write with auto precharge pulses pre_start_o[bank] TWR cycles after another bank's READ or WRITE interrupts it. If nothing interrupts it, the pulse comes BL+TWR cycles after the write is registered.
- R10: A READ or WRITE to a bank that is idle, precharging, waiting out write recovery, or holding a pending auto precharge pulses err_o in the cycle it is registered. The command has no effect on the bus or on any bank.
- R11: A PRECHARGE (cmd_i=4) to an open bank pulses pre_start_o for that bank in the cycle it is registered. The bank then stays closed for TRP cycles, and READ or WRITE to it is an error.
- R12: ACTIVE (cmd_i=1) opens an idle bank, after which READ and WRITE to it are accepted. cmd_i=0 is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Registered command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank_i | input | 2 | Target bank |
| ap_i | input | 1 | Auto precharge with READ/WRITE |
| cas3_i | input | 1 | CAS latency select: 1 gives 3 clocks, 0 gives 2 |
| burst_len_i | input | 2 | Burst length code, BL = 1 << code |
| bus_dir_o | output | 2 | Data bus direction: 0 idle, 1 read, 2 write |
| bus_bank_o | output | 2 | Bank owning the data bus (0 when idle) |
| pre_start_o | output | 4 | Per-bank precharge-start pulse |
| dqm_req_o | output | 1 | DQM masking was required ahead of this WRITE |
| dqm_lead_o | output | 2 | Required DQM lead in clocks (1 or 2) when dqm_req_o is high |
| err_o | output | 1 | Illegal READ/WRITE, command ignored |

## Verification
All outputs are registered, so the result of the command registered at edge t is read half a clock after that edge. The bench drives on the falling edge and samples on the next falling edge, once per cycle. Write ownership, error and DQM pulses belong to cycle t itself. Read data belongs to cycle t+CL, and an uninterrupted burst ends at t+BL. Precharge of an interrupted write comes at the interrupt cycle plus TWR. For each scenario the bench computes the expected bus owner, precharge vector, DQM flag and error flag for every cycle of a window long enough to cover the second burst's own precharge, and compares each one in that cycle.

// File: rtl/sdram_cap_pkg.sv
package sdram_cap_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_OPEN,
    BK_RD,
    BK_WR,
    BK_WREC,
    BK_PRE
  } bank_st_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_WR   = 2'd2
  } bus_dir_e;

endpackage

// File: rtl/sdram_cap_bank.sv
module sdram_cap_bank
  import sdram_cap_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TWR   = 2,
  parameter int TRP   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             hit_i,
  input  logic             is_wr_i,
  input  logic             ap_i,
  input  logic             cut_i,
  input  logic             pre_cmd_i,
  input  logic [CNT_W-1:0] beats_i,
  output logic             ready_o,
  output logic             pre_start_o
);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ap_q, ap_d;
  logic             in_burst, burst_end;

  assign in_burst  = (st_q == BK_RD) || (st_q == BK_WR);
  // another bank's access or the last beat closes the burst window
  assign burst_end = in_burst && (cut_i || cnt_q == CNT_W'(1));

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    ap_d        = ap_q;
    pre_start_o = 1'b0;
    unique case (st_q)
      BK_IDLE: if (open_i) st_d = BK_OPEN;
      BK_OPEN: begin
        if (pre_cmd_i) begin
          st_d        = BK_PRE;
          cnt_d       = CNT_W'(TRP);
          pre_start_o = 1'b1;
        end
      end
      BK_RD, BK_WR: begin
        if (pre_cmd_i && !ap_q) begin
          st_d        = BK_PRE;
          cnt_d       = CNT_W'(TRP);
          pre_start_o = 1'b1;
        end else if (burst_end) begin
          if (!ap_q) begin
            st_d = BK_OPEN;
          end else if (st_q == BK_RD) begin
            st_d        = BK_PRE;
            cnt_d       = CNT_W'(TRP);
            pre_start_o = 1'b1;
          end else begin
            st_d  = BK_WREC;
            cnt_d = CNT_W'(TWR);
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      BK_WREC: begin
        if (cnt_q == CNT_W'(1)) begin
          st_d        = BK_PRE;
          cnt_d       = CNT_W'(TRP);
          pre_start_o = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      BK_PRE: begin
        if (cnt_q == CNT_W'(1)) st_d = BK_IDLE;
        else cnt_d = cnt_q - CNT_W'(1);
      end
      default: st_d = BK_IDLE;
    endcase
    if (hit_i) begin
      st_d  = is_wr_i ? BK_WR : BK_RD;
      cnt_d = beats_i;
      ap_d  = ap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ap_q  <= ap_d;
    end
  end

  assign ready_o = (st_q == BK_OPEN) || (in_burst && !ap_q);

endmodule

// File: rtl/sdram_cap_bus.sv
module sdram_cap_bus
  import sdram_cap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_go_i,
  input  logic              wr_go_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              cas3_i,
  input  logic [CNT_W-1:0]  beats_i,
  output logic [1:0]        dir_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              rd_live_o
);

  localparam int PIPE = 3;

  logic [PIPE-1:0]   pv_q, lat_mask;
  logic [BANK_W-1:0] pb_q [PIPE];
  bus_dir_e          dir_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  left_q;
  logic              start_v;
  logic [BANK_W-1:0] start_b;

  assign lat_mask  = cas3_i ? 3'b111 : 3'b011;
  assign start_v   = cas3_i ? pv_q[2] : pv_q[1];
  assign start_b   = cas3_i ? pb_q[2] : pb_q[1];
  assign rd_live_o = (|(pv_q & lat_mask)) || (dir_q == BUS_RD && left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q   <= '0;
      for (int i = 0; i < PIPE; i++) pb_q[i] <= '0;
      dir_q  <= BUS_IDLE;
      bank_q <= '0;
      left_q <= '0;
    end else begin
      pv_q <= wr_go_i ? '0 : {pv_q[PIPE-2:0], rd_go_i};
      pb_q[0] <= bank_i;
      for (int i = 1; i < PIPE; i++) pb_q[i] <= pb_q[i-1];
      if (wr_go_i) begin
        dir_q  <= BUS_WR;
        bank_q <= bank_i;
        left_q <= beats_i - CNT_W'(1);
      end else if (start_v) begin
        dir_q  <= BUS_RD;
        bank_q <= start_b;
        left_q <= beats_i - CNT_W'(1);
      end else if (rd_go_i && dir_q == BUS_WR) begin
        // write cut by a read: bus turns around idle until read data
        dir_q  <= BUS_IDLE;
        bank_q <= '0;
        left_q <= '0;
      end else if (left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
      end else begin
        dir_q  <= BUS_IDLE;
        bank_q <= '0;
      end
    end
  end

  assign dir_o  = dir_q;
  assign bank_o = bank_q;

endmodule

// File: rtl/sdram_cap_tracker.sv
module sdram_cap_tracker
  import sdram_cap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MAX_BL    = 8,
  parameter int TWR       = 2,
  parameter int TRP       = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         ap_i,
  input  logic                         cas3_i,
  input  logic [1:0]                   burst_len_i,
  output logic [1:0]                   bus_dir_o,
  output logic [$clog2(NUM_BANKS)-1:0] bus_bank_o,
  output logic [NUM_BANKS-1:0]         pre_start_o,
  output logic                         dqm_req_o,
  output logic [1:0]                   dqm_lead_o,
  output logic                         err_o
);

  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int CNT_MAX = (MAX_BL > TWR) ? ((MAX_BL > TRP) ? MAX_BL : TRP)
                                          : ((TWR > TRP) ? TWR : TRP);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic                 is_rd, is_wr, is_acc, rd_go, wr_go, rd_live;
  logic [NUM_BANKS-1:0] ready, pre_start;
  logic [CNT_W-1:0]     beats;
  logic                 rd_ap_q, dqm_q, err_q;
  logic [1:0]           lead_q;
  logic [NUM_BANKS-1:0] pre_q;

  assign is_rd  = (cmd_i == CMD_RD);
  assign is_wr  = (cmd_i == CMD_WR);
  assign is_acc = (is_rd || is_wr) && ready[bank_i];
  assign rd_go  = is_rd && is_acc;
  assign wr_go  = is_wr && is_acc;
  assign beats  = CNT_W'(1) << burst_len_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));
    sdram_cap_bank #(.CNT_W(CNT_W), .TWR(TWR), .TRP(TRP)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .open_i     (sel && cmd_i == CMD_ACT),
      .hit_i      (sel && is_acc),
      .is_wr_i    (is_wr),
      .ap_i       (ap_i),
      .cut_i      (!sel && is_acc),
      .pre_cmd_i  (sel && cmd_i == CMD_PRE),
      .beats_i    (beats),
      .ready_o    (ready[b]),
      .pre_start_o(pre_start[b])
    );
  end

  sdram_cap_bus #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_go_i  (rd_go),
    .wr_go_i  (wr_go),
    .bank_i   (bank_i),
    .cas3_i   (cas3_i),
    .beats_i  (beats),
    .dir_o    (bus_dir_o),
    .bank_o   (bus_bank_o),
    .rd_live_o(rd_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ap_q <= 1'b0;
      dqm_q   <= 1'b0;
      lead_q  <= 2'd0;
      err_q   <= 1'b0;
      pre_q   <= '0;
    end else begin
      if (rd_go) rd_ap_q <= ap_i;
      dqm_q  <= wr_go && rd_live;
      lead_q <= (wr_go && rd_live) ? (rd_ap_q ? 2'd2 : 2'd1) : 2'd0;
      err_q  <= (is_rd || is_wr) && !ready[bank_i];
      pre_q  <= pre_start;
    end
  end

  assign pre_start_o = pre_q;
  assign dqm_req_o   = dqm_q;
  assign dqm_lead_o  = lead_q;
  assign err_o       = err_q;

endmodule

// File: rtl/sdram_cap_tracker_chk.sv
module sdram_cap_tracker_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [2:0]                   cmd_i,
  input logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input logic [1:0]                   bus_dir_o,
  input logic [$clog2(NUM_BANKS)-1:0] bus_bank_o,
  input logic [NUM_BANKS-1:0]         pre_start_o,
  input logic                         dqm_req_o,
  input logic [1:0]                   dqm_lead_o,
  input logic                         err_o
);

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (bus_dir_o == 2'd0 && pre_start_o == '0 && !dqm_req_o && !err_o);
    end
  end

  // R2
  write_owns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3) |=> (err_o || (bus_dir_o == 2'd2 && bus_bank_o == $past(bank_i))));

  // R7
  dqm_with_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_req_o |-> (bus_dir_o == 2'd2 && !err_o));

  // R7
  dqm_lead_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_req_o |-> (dqm_lead_o == 2'd1 || dqm_lead_o == 2'd2));

  // R11
  access_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == 3'd2 || cmd_i == 3'd3) && pre_start_o[bank_i]) |=> err_o);

  // R10
  err_no_dqm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !dqm_req_o);

endmodule

bind sdram_cap_tracker sdram_cap_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .bank_i     (bank_i),
  .bus_dir_o  (bus_dir_o),
  .bus_bank_o (bus_bank_o),
  .pre_start_o(pre_start_o),
  .dqm_req_o  (dqm_req_o),
  .dqm_lead_o (dqm_lead_o),
  .err_o      (err_o)
);

// File: tb/sdram_cap_tracker_test.sv
`timescale 1ns/1ps
module sdram_cap_tracker_test;

  localparam int TWR_V = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic       ap = 1'b0;
  logic       cas3 = 1'b0;
  logic [1:0] blen = 2'd3;
  logic [1:0] bus_dir, bus_bank, dqm_lead;
  logic [3:0] pre_start;
  logic       dqm_req, err;

  int n_run = 0;
  int n_fail = 0;

  // scenario state
  int s_k1, s_ap1, s_k2, s_ap2, s_cl, s_bl, s_gap, s_n, s_m;

  always #2 clk = ~clk;

  sdram_cap_tracker #(.TWR(TWR_V)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
    .cas3_i(cas3), .burst_len_i(blen), .bus_dir_o(bus_dir), .bus_bank_o(bus_bank),
    .pre_start_o(pre_start), .dqm_req_o(dqm_req), .dqm_lead_o(dqm_lead), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bus_now();
    return int'(bus_dir) * 4 + int'(bus_bank);
  endfunction

  task automatic drive(input int c, input int b, input int a);
    cmd  = 3'(c);
    bank = 2'(b);
    ap   = a[0];
  endtask

  task automatic issue(input int c, input int b, input int a);
    drive(c, b, a);
    @(negedge clk);
    drive(0, 0, 0);
  endtask

  task automatic idle(input int n);
    drive(0, 0, 0);
    repeat (n) @(negedge clk);
  endtask

  function automatic int e_bus(input int r);
    int ms, ns, ne;
    if (s_k2 != 0) begin
      ms = (s_k2 == 2) ? s_gap + s_cl : s_gap;
      if (r >= ms && r < ms + s_bl) return (s_k2 - 1) * 4 + s_m;
    end
    if (s_k1 == 2) begin
      ns = s_cl;
      ne = (s_k2 == 0) ? s_cl + s_bl : ((s_k2 == 2) ? s_gap + s_cl : s_gap);
      if (ne > s_cl + s_bl) ne = s_cl + s_bl;
    end else begin
      ns = 0;
      ne = (s_k2 == 0) ? s_bl : s_gap;
    end
    if (r >= ns && r < ne) return (s_k1 - 1) * 4 + s_n;
    return 0;
  endfunction

  function automatic int e_pre(input int r);
    int v, t;
    v = 0;
    if (s_ap1 != 0) begin
      t = (s_k2 == 0) ? s_bl : s_gap;
      if (s_k1 == 3) t = t + TWR_V;
      if (r == t) v = v | (1 << s_n);
    end
    if (s_k2 != 0 && s_ap2 != 0) begin
      t = s_gap + s_bl + ((s_k2 == 3) ? TWR_V : 0);
      if (r == t) v = v | (1 << s_m);
    end
    return v;
  endfunction

  function automatic string bus_tag();
    if (s_k2 == 0) return (s_k1 == 2) ? "R3 read burst" : "R2 write burst";
    if (s_k1 == 2 && s_k2 == 2) return "R4 read by read";
    if (s_k1 == 2) return "R5 read by write";
    return "R6 write interrupted";
  endfunction

  task automatic run_scn(input int k1, input int ap1, input int k2, input int ap2,
                         input int cl3, input int blc, input int gap,
                         input int n, input int m);
    int last;
    s_k1 = k1; s_ap1 = ap1; s_k2 = k2; s_ap2 = ap2;
    s_cl = cl3 ? 3 : 2; s_bl = 1 << blc; s_gap = gap; s_n = n; s_m = m;
    cas3 = cl3[0];
    blen = 2'(blc);
    idle(3);
    issue(1, n, 0);
    issue(1, m, 0);
    idle(2);
    last = gap + s_bl + s_cl + TWR_V + 2;
    for (int r = 0; r <= last; r++) begin
      if (r == 0) drive(k1, n, ap1);
      else if (r == gap && k2 != 0) drive(k2, m, ap2);
      else drive(0, 0, 0);
      @(negedge clk);
      chk(bus_tag(), bus_now(), e_bus(r));
      chk((k1 == 2) ? "R8 precharge start" : "R9 precharge start", int'(pre_start), e_pre(r));
      chk("R7 dqm request", int'(dqm_req), (r == gap && k1 == 2 && k2 == 3) ? 1 : 0);
      if (r == gap && k1 == 2 && k2 == 3) chk("R7 dqm lead", int'(dqm_lead), ap1 ? 2 : 1);
      chk("R10 no error", int'(err), 0);
    end
    idle(14);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int bl_r, n_r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 bus idle", bus_now(), 0);
    chk("R1 precharge", int'(pre_start), 0);
    chk("R1 dqm", int'(dqm_req) + int'(dqm_lead), 0);
    chk("R1 err", int'(err), 0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 after release", bus_now() + int'(pre_start) + int'(err), 0);

    // R10 read to idle bank is flagged and ignored
    cas3 = 1'b0; blen = 2'd1;
    issue(2, 2, 0);
    chk("R10 err idle bank", int'(err), 1);
    for (int r = 1; r <= 5; r++) begin
      idle(1);
      chk("R10 ignored read", bus_now(), 0);
    end

    // R10 access to bank with pending auto precharge
    blen = 2'd2;
    issue(1, 2, 0);
    issue(3, 2, 1);
    chk("R2 write start", bus_now(), 2 * 4 + 2);
    issue(3, 2, 0);
    chk("R10 err pending ap", int'(err), 1);
    chk("R10 burst kept", bus_now(), 2 * 4 + 2);
    for (int r = 2; r <= 7; r++) begin
      idle(1);
      chk("R10 burst kept", bus_now(), (r < 4) ? 10 : 0);
      chk("R9 uninterrupted write", int'(pre_start), (r == 4 + TWR_V) ? 4 : 0);
    end
    idle(6);

    // R11 explicit precharge, R12 reopen
    issue(1, 1, 0);
    issue(4, 1, 0);
    chk("R11 explicit precharge", int'(pre_start), 2);
    issue(2, 1, 0);
    chk("R11 access while closing", int'(err), 1);
    idle(1);
    issue(1, 1, 0);
    issue(2, 1, 0);
    chk("R12 read after reopen", int'(err), 0);
    idle(2);
    chk("R12 read data", bus_now(), 1 * 4 + 1);
    idle(12);

    // eight interruption cases at both CAS latencies
    for (int cl = 0; cl < 2; cl++)
      for (int k1 = 2; k1 <= 3; k1++)
        for (int a1 = 0; a1 < 2; a1++)
          for (int k2 = 2; k2 <= 3; k2++)
            run_scn(k1, a1, k2, a1 ^ k2 % 2, cl, 3, 3, 0, 1);

    // uninterrupted auto precharge bursts
    for (int k1 = 2; k1 <= 3; k1++)
      run_scn(k1, 1, 0, 0, k1 - 2, 2, 0, 3, 2);

    // read cut by write before its data appears
    run_scn(2, 1, 3, 0, 1, 3, 1, 2, 0);

    // constrained random interruption scenarios
    for (int i = 0; i < 40; i++) begin
      bl_r = 1 + int'($urandom % 3);
      n_r  = int'($urandom % 4);
      run_scn(2 + int'($urandom % 2), int'($urandom % 2),
              (($urandom % 5) == 0) ? 0 : 2 + int'($urandom % 2), int'($urandom % 2),
              int'($urandom % 2), bl_r, 1 + int'($urandom % ((1 << bl_r) - 1)),
              n_r, (n_r + 1 + int'($urandom % 3)) % 4);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule